// File: doc/BRIEF.md
# Modular Polynomial Accumulator with Registered Read-Ahead

This block builds a set of result polynomials t[i] = e[i] + sum over j of P[i][j], where every P[i][j] is a product polynomial that arrives one coefficient at a time from an external multiplier. The block walks the terms itself. After a start pulse it takes i and j from 0 up to rank-1, with j varying fastest. For each product coefficient it fetches an addend, adds the two modulo q = 3329 and writes the result back into the result bank.

For the first term of a row (j = 0) the addend is the seed polynomial e[i]. The seed sits in the noise bank at relative slot rank+i. For every later term the addend is the partial result t[i] already held in the result bank. Both banks are external RAMs with a registered read, so read data appears one cycle after the address. The block therefore presents each address one cycle before the coefficient that needs it. It tracks the product-valid strobe, which can have gaps and does not follow a fixed pattern. The write to the result bank uses the same index that an earlier read of that bank fetched. The read pointer always runs ahead of the write pointer, so the block never reads and writes the same entry in one cycle.

Each polynomial has N = 256 coefficients of 12 bits. A bank address is slot*256 + index.

Top module: `poly_acc_rmw`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy_o`, `term_done_o`, `all_done_o`, `t_wr_en_o`, `se_rd_en_o` and `t_rd_en_o` are all low.
- R2: While busy, when the addressed term has j = 0, only the noise bank is read (`se_rd_en_o` high, `t_rd_en_o` low). The noise-bank address is (rank+i)*256 + x.
- R3: While busy, when the addressed term has j > 0, only the result bank is read (`t_rd_en_o` high, `se_rd_en_o` low). The result-bank address is i*256 + x.
- R4: In R2 and R3, x is the current index plus 1 when `prod_vld_i` is high, and the current index when it is low. When a product is accepted at index 255, the address points at index 0 of the next term, so back-to-back products across a term boundary are accepted.
- R5: Each product accepted while busy causes one write to the result bank in the same cycle. The address is i*256 + index. The data is (addend + coefficient) mod 3329, formed with one conditional subtraction. A cycle with no product writes nothing.
- R6: After the write at index 255, the term ends and `term_done_o` pulses high for the next cycle. j then advances while j+1 < rank; otherwise j returns to 0 and i advances.
- R7: After the last term (i = j = rank-1), `busy_o` falls and `all_done_o` pulses in the same cycle. While not busy, products are ignored and nothing is written.
- R8: A result-bank write is never to the same address as a result-bank read in the same cycle, and the result is correct with the read-old semantics of the RAM. This holds for any valid cadence: an idle cycle then two products, every cycle, or every other cycle.
- R9: The rank is captured when `start_i` is high. Later changes on `rank_i` have no effect on the pass in progress. Products are accepted from the second cycle after the start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a pass and capture the rank |
| rank_i | input | RW (3) | Number of rows and columns, 2..KMAX |
| prod_vld_i | input | 1 | Product coefficient valid |
| prod_coef_i | input | 12 | Product coefficient, below q |
| se_rd_en_o | output | 1 | Noise-bank read enable |
| se_rd_addr_o | output | SEAW (11) | Noise-bank read address |
| se_rd_data_i | input | 12 | Noise-bank registered read data |
| t_rd_en_o | output | 1 | Result-bank read enable |
| t_rd_addr_o | output | TAW (10) | Result-bank read address |
| t_rd_data_i | input | 12 | Result-bank registered read data (read-old) |
| t_wr_en_o | output | 1 | Result-bank write enable |
| t_wr_addr_o | output | TAW (10) | Result-bank write address |
| t_wr_data_o | output | 12 | Result-bank write data |
| busy_o | output | 1 | Pass in progress |
| term_done_o | output | 1 | One-cycle pulse after the last write of a term |
| all_done_o | output | 1 | One-cycle pulse when the pass ends |

## Verification
The assertions check, on every cycle, the properties that do not depend on stored data:
- no result-bank write ever collides with a result-bank read;
- a result-bank read issued alongside a write targets the next index;
- every written value is below q;
- term-done only follows a write at index 255;
- the busy flag only ends together with the all-done pulse;
- the block stays quiet through reset.

Only the bench scenarios can show the properties that depend on stored data and on the sequence of terms:
- correct addend selection between the banks;
- correct modular sums, including wrap cases at exactly q;
- correct term order for ranks 2, 3 and 4 under several valid cadences;
- read-old correctness of the running result;
- that a rank change after the start pulse is ignored.

// File: rtl/poly_acc_pkg.sv
`timescale 1ns/1ps
package poly_acc_pkg;

    localparam int COEF_W = 12;
    localparam logic [COEF_W:0] MOD_Q = 13'd3329;

    typedef logic [COEF_W-1:0] coef_t;

    // where the addend of the next consumed coefficient comes from
    typedef enum logic {
        SRC_SEED = 1'b0,
        SRC_RUN  = 1'b1
    } addend_src_e;

    // sum of two residues below q, reduced by one conditional subtract
    function automatic coef_t mod_add(input coef_t a, input coef_t b);
        logic [COEF_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= MOD_Q) s = s - MOD_Q;
        return s[COEF_W-1:0];
    endfunction

endpackage

// File: rtl/acc_term_seq.sv
`timescale 1ns/1ps
// Term walker: owns (i, j, index), latches the rank, flags term/pass end.
module acc_term_seq #(
    parameter int KMAX = 4,
    parameter int N    = 256,
    localparam int XW  = $clog2(N),
    localparam int IW  = $clog2(KMAX),
    localparam int RW  = $clog2(KMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [RW-1:0] rank_i,
    input  logic          prod_vld_i,
    output logic          busy_o,
    output logic [RW-1:0] rank_o,
    output logic [IW-1:0] i_o,
    output logic [IW-1:0] j_o,
    output logic [XW-1:0] idx_o,
    output logic [IW-1:0] nxt_i_o,
    output logic [IW-1:0] nxt_j_o,
    output logic          term_done_o,
    output logic          all_done_o
);
    localparam logic [XW-1:0] LAST_X = XW'(N - 1);

    logic [RW-1:0] rank_q;
    logic [IW-1:0] i_q, j_q;
    logic [XW-1:0] x_q;
    logic          busy_q, tdone_q, adone_q;
    logic          j_wraps, i_wraps, fire;

    assign j_wraps = (RW'(j_q) + RW'(1)) >= rank_q;
    assign i_wraps = (RW'(i_q) + RW'(1)) >= rank_q;
    assign fire    = busy_q && prod_vld_i;

    always_comb begin
        if (j_wraps) begin
            nxt_j_o = '0;
            nxt_i_o = i_q + IW'(1);
        end else begin
            nxt_j_o = j_q + IW'(1);
            nxt_i_o = i_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            rank_q  <= '0;
            i_q     <= '0;
            j_q     <= '0;
            x_q     <= '0;
            tdone_q <= 1'b0;
            adone_q <= 1'b0;
        end else begin
            tdone_q <= 1'b0;
            adone_q <= 1'b0;
            if (start_i) begin
                busy_q <= 1'b1;
                rank_q <= rank_i;
                i_q    <= '0;
                j_q    <= '0;
                x_q    <= '0;
            end else if (fire) begin
                x_q <= x_q + XW'(1);
                if (x_q == LAST_X) begin
                    tdone_q <= 1'b1;
                    i_q     <= nxt_i_o;
                    j_q     <= nxt_j_o;
                    if (j_wraps && i_wraps) begin
                        busy_q  <= 1'b0;
                        adone_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy_o      = busy_q;
    assign rank_o      = rank_q;
    assign i_o         = i_q;
    assign j_o         = j_q;
    assign idx_o       = x_q;
    assign term_done_o = tdone_q;
    assign all_done_o  = adone_q;

endmodule

// File: rtl/acc_rd_addr.sv
`timescale 1ns/1ps
// Read-ahead address generator: points one index ahead on a product,
// and at index 0 of the next term when the current term closes.
module acc_rd_addr #(
    parameter int KMAX  = 4,
    parameter int N     = 256,
    localparam int XW   = $clog2(N),
    localparam int IW   = $clog2(KMAX),
    localparam int RW   = $clog2(KMAX + 1),
    localparam int SESW = $clog2(2 * KMAX),
    localparam int SEAW = SESW + XW,
    localparam int TAW  = IW + XW
) (
    input  logic            busy_i,
    input  logic            prod_vld_i,
    input  logic [RW-1:0]   rank_i,
    input  logic [IW-1:0]   i_i,
    input  logic [IW-1:0]   j_i,
    input  logic [XW-1:0]   idx_i,
    input  logic [IW-1:0]   nxt_i_i,
    input  logic [IW-1:0]   nxt_j_i,
    output logic            se_en_o,
    output logic [SEAW-1:0] se_addr_o,
    output logic            t_en_o,
    output logic [TAW-1:0]  t_addr_o,
    output poly_acc_pkg::addend_src_e src_o
);
    import poly_acc_pkg::*;

    logic [IW-1:0]   a_i, a_j;
    logic [XW-1:0]   a_x;
    logic [SESW-1:0] se_slot;

    always_comb begin
        a_i = i_i;
        a_j = j_i;
        a_x = idx_i;
        if (prod_vld_i) begin
            if (idx_i == XW'(N - 1)) begin
                a_i = nxt_i_i;
                a_j = nxt_j_i;
                a_x = '0;
            end else begin
                a_x = idx_i + XW'(1);
            end
        end
    end

    assign src_o     = (a_j == '0) ? SRC_SEED : SRC_RUN;
    assign se_slot   = SESW'(rank_i) + SESW'(a_i);
    assign se_en_o   = busy_i && (src_o == SRC_SEED);
    assign t_en_o    = busy_i && (src_o == SRC_RUN);
    assign se_addr_o = {se_slot, a_x};
    assign t_addr_o  = {a_i, a_x};

endmodule

// File: rtl/acc_mod_add.sv
`timescale 1ns/1ps
// Addend selection and modular sum.
module acc_mod_add (
    input  poly_acc_pkg::addend_src_e src_i,
    input  poly_acc_pkg::coef_t       seed_i,
    input  poly_acc_pkg::coef_t       run_i,
    input  poly_acc_pkg::coef_t       prod_i,
    output poly_acc_pkg::coef_t       sum_o
);
    import poly_acc_pkg::*;

    coef_t addend;

    assign addend = (src_i == SRC_SEED) ? seed_i : run_i;
    assign sum_o  = mod_add(addend, prod_i);

endmodule

// File: rtl/poly_acc_rmw.sv
`timescale 1ns/1ps
module poly_acc_rmw #(
    parameter int KMAX  = 4,
    parameter int N     = 256,
    localparam int XW   = $clog2(N),
    localparam int IW   = $clog2(KMAX),
    localparam int RW   = $clog2(KMAX + 1),
    localparam int SEAW = $clog2(2 * KMAX) + XW,
    localparam int TAW  = IW + XW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [RW-1:0]   rank_i,
    input  logic            prod_vld_i,
    input  logic [11:0]     prod_coef_i,
    output logic            se_rd_en_o,
    output logic [SEAW-1:0] se_rd_addr_o,
    input  logic [11:0]     se_rd_data_i,
    output logic            t_rd_en_o,
    output logic [TAW-1:0]  t_rd_addr_o,
    input  logic [11:0]     t_rd_data_i,
    output logic            t_wr_en_o,
    output logic [TAW-1:0]  t_wr_addr_o,
    output logic [11:0]     t_wr_data_o,
    output logic            busy_o,
    output logic            term_done_o,
    output logic            all_done_o
);
    import poly_acc_pkg::*;

    logic [RW-1:0] rank_q;
    logic [IW-1:0] cur_i, cur_j, nxt_i, nxt_j;
    logic [XW-1:0] cur_x;
    addend_src_e   src_now, src_q;
    coef_t         sum;

    acc_term_seq #(.KMAX(KMAX), .N(N)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rank_i      (rank_i),
        .prod_vld_i  (prod_vld_i),
        .busy_o      (busy_o),
        .rank_o      (rank_q),
        .i_o         (cur_i),
        .j_o         (cur_j),
        .idx_o       (cur_x),
        .nxt_i_o     (nxt_i),
        .nxt_j_o     (nxt_j),
        .term_done_o (term_done_o),
        .all_done_o  (all_done_o)
    );

    acc_rd_addr #(.KMAX(KMAX), .N(N)) u_addr (
        .busy_i     (busy_o),
        .prod_vld_i (prod_vld_i),
        .rank_i     (rank_q),
        .i_i        (cur_i),
        .j_i        (cur_j),
        .idx_i      (cur_x),
        .nxt_i_i    (nxt_i),
        .nxt_j_i    (nxt_j),
        .se_en_o    (se_rd_en_o),
        .se_addr_o  (se_rd_addr_o),
        .t_en_o     (t_rd_en_o),
        .t_addr_o   (t_rd_addr_o),
        .src_o      (src_now)
    );

    // the bank chosen with an address is the bank whose data lands next cycle
    always_ff @(posedge clk) begin
        if (rst) src_q <= SRC_SEED;
        else     src_q <= src_now;
    end

    acc_mod_add u_add (
        .src_i  (src_q),
        .seed_i (se_rd_data_i),
        .run_i  (t_rd_data_i),
        .prod_i (prod_coef_i),
        .sum_o  (sum)
    );

    assign t_wr_en_o   = busy_o && prod_vld_i;
    assign t_wr_addr_o = {cur_i, cur_x};
    assign t_wr_data_o = sum;

endmodule

// File: rtl/poly_acc_chk.sv
`timescale 1ns/1ps
module poly_acc_chk #(
    parameter int XW   = 8,
    parameter int SEAW = 11,
    parameter int TAW  = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           busy_o,
    input logic           se_rd_en_o,
    input logic           t_rd_en_o,
    input logic [TAW-1:0] t_rd_addr_o,
    input logic           t_wr_en_o,
    input logic [TAW-1:0] t_wr_addr_o,
    input logic [11:0]    t_wr_data_o,
    input logic           term_done_o,
    input logic           all_done_o
);
    import poly_acc_pkg::*;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy_o && !t_wr_en_o && !se_rd_en_o && !t_rd_en_o
                 && !term_done_o && !all_done_o));

    a_r2_one_bank: assert property (@(posedge clk) disable iff (rst)
        $onehot0({se_rd_en_o, t_rd_en_o}));

    a_r4_read_ahead: assert property (@(posedge clk) disable iff (rst)
        (t_wr_en_o && t_rd_en_o && (t_wr_addr_o[XW-1:0] != {XW{1'b1}}))
        |-> (t_rd_addr_o == t_wr_addr_o + TAW'(1)));

    a_r5_below_q: assert property (@(posedge clk) disable iff (rst)
        t_wr_en_o |-> ({1'b0, t_wr_data_o} < MOD_Q));

    a_r6_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (term_done_o && !$past(rst)) |->
        ($past(t_wr_en_o) && ($past(t_wr_addr_o[XW-1:0]) == {XW{1'b1}})));

    a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && !$past(rst)) |-> all_done_o);

    a_r8_no_collision: assert property (@(posedge clk) disable iff (rst)
        (t_wr_en_o && t_rd_en_o) |-> (t_rd_addr_o != t_wr_addr_o));

endmodule

bind poly_acc_rmw poly_acc_chk #(.XW(XW), .SEAW(SEAW), .TAW(TAW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_o      (busy_o),
    .se_rd_en_o  (se_rd_en_o),
    .t_rd_en_o   (t_rd_en_o),
    .t_rd_addr_o (t_rd_addr_o),
    .t_wr_en_o   (t_wr_en_o),
    .t_wr_addr_o (t_wr_addr_o),
    .t_wr_data_o (t_wr_data_o),
    .term_done_o (term_done_o),
    .all_done_o  (all_done_o)
);

// File: tb/tb_poly_acc_rmw.sv
`timescale 1ns/1ps
module tb_poly_acc_rmw;
    localparam int KMAX = 4;
    localparam int N    = 256;
    localparam int Q    = 3329;
    localparam int NCFG = 5;
    // run table: rank, valid cadence (0: idle,1,1  1: every cycle
    // 2: every other  3: pseudo-random), data pattern (0: hashed 1: edge sums)
    localparam int CFG_RANK [NCFG] = '{2, 3, 4, 2, 4};
    localparam int CFG_CAD  [NCFG] = '{0, 1, 2, 3, 0};
    localparam int CFG_PAT  [NCFG] = '{0, 0, 0, 1, 1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  rank_i = 3'd0;
    logic        prod_vld_i = 1'b0;
    logic [11:0] prod_coef_i = 12'd0;
    logic        se_rd_en_o, t_rd_en_o, t_wr_en_o;
    logic [10:0] se_rd_addr_o;
    logic [9:0]  t_rd_addr_o, t_wr_addr_o;
    logic [11:0] se_rd_data_i, t_rd_data_i, t_wr_data_o;
    logic        busy_o, term_done_o, all_done_o;

    always #5 clk = ~clk;

    poly_acc_rmw #(.KMAX(KMAX), .N(N)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .rank_i(rank_i),
        .prod_vld_i(prod_vld_i), .prod_coef_i(prod_coef_i),
        .se_rd_en_o(se_rd_en_o), .se_rd_addr_o(se_rd_addr_o), .se_rd_data_i(se_rd_data_i),
        .t_rd_en_o(t_rd_en_o), .t_rd_addr_o(t_rd_addr_o), .t_rd_data_i(t_rd_data_i),
        .t_wr_en_o(t_wr_en_o), .t_wr_addr_o(t_wr_addr_o), .t_wr_data_o(t_wr_data_o),
        .busy_o(busy_o), .term_done_o(term_done_o), .all_done_o(all_done_o)
    );

    // registered-read RAM models, read returns old data on a same-cycle write
    logic [11:0] se_mem [2*KMAX*N];
    logic [11:0] t_mem  [KMAX*N];
    always @(posedge clk) begin
        if (se_rd_en_o) se_rd_data_i <= se_mem[se_rd_addr_o];
        if (t_rd_en_o)  t_rd_data_i  <= t_mem[t_rd_addr_o];
        if (t_wr_en_o)  t_mem[t_wr_addr_o] <= t_wr_data_o;
    end

    int checks = 0;
    int fails  = 0;
    int exp_t [KMAX*N];
    int m_i, m_j, m_x, m_rank, n_tdone, n_adone;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: independent model of term order, addresses and sums
    always @(negedge clk) begin
        if (start_i) begin
            m_i = 0; m_j = 0; m_x = 0; m_rank = int'(rank_i);
            n_tdone = 0; n_adone = 0;
        end else if (!rst) begin
            if (term_done_o) n_tdone++;
            if (all_done_o)  n_adone++;
            if (busy_o) begin
                int ai, aj, ax, e, addend;
                bit skip;
                ai = m_i; aj = m_j; ax = m_x; skip = 0;
                if (prod_vld_i) begin
                    if (m_x == N-1) begin
                        ax = 0;
                        if (m_j + 1 < m_rank) aj = m_j + 1;
                        else begin aj = 0; ai = m_i + 1; skip = (ai >= m_rank); end
                    end else ax = m_x + 1;
                end
                if (!skip) begin
                    if (aj == 0)
                        check(se_rd_en_o && !t_rd_en_o &&
                              int'(se_rd_addr_o) == (m_rank + ai) * N + ax,
                              "R2 R4 seed read address", int'(se_rd_addr_o),
                              (m_rank + ai) * N + ax);
                    else
                        check(t_rd_en_o && !se_rd_en_o &&
                              int'(t_rd_addr_o) == ai * N + ax,
                              "R3 R4 running read address", int'(t_rd_addr_o), ai * N + ax);
                end
                if (prod_vld_i) begin
                    addend = (m_j == 0) ? int'(se_mem[(m_rank + m_i) * N + m_x])
                                        : exp_t[m_i * N + m_x];
                    e = (addend + int'(prod_coef_i)) % Q;
                    check(t_wr_en_o && int'(t_wr_addr_o) == m_i * N + m_x,
                          "R5 write address", int'(t_wr_addr_o), m_i * N + m_x);
                    check(int'(t_wr_data_o) == e, "R5 modular sum",
                          int'(t_wr_data_o), e);
                    exp_t[m_i * N + m_x] = e;
                    m_i = ai; m_j = aj; m_x = ax;
                end else begin
                    check(!t_wr_en_o, "R5 no write without product", int'(t_wr_en_o), 0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        repeat (4) @(posedge clk);
        #1;
        // R1: quiet in reset and the cycle after
        @(negedge clk);
        check(!busy_o && !t_wr_en_o && !se_rd_en_o && !t_rd_en_o,
              "R1 outputs in reset", int'(busy_o), 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !term_done_o && !all_done_o && !t_wr_en_o,
              "R1 outputs after reset", int'(busy_o), 0);

        // R7: products while idle are ignored
        prod_vld_i = 1'b1; prod_coef_i = 12'd5;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!t_wr_en_o && !busy_o, "R7 idle product ignored", int'(t_wr_en_o), 0);
        end
        @(posedge clk); #1 prod_vld_i = 1'b0;

        for (int c = 0; c < NCFG; c++) begin
            int rk, total, issued, n, mism;
            rk = CFG_RANK[c];
            total = rk * rk * N;
            for (int a = 0; a < 2*KMAX*N; a++)
                se_mem[a] = (CFG_PAT[c] == 1) ? 12'd3328 : 12'((a * 37 + 5 + c) % Q);
            for (int a = 0; a < KMAX*N; a++) t_mem[a] = 12'd0;
            lfsr = 8'hA5;
            @(posedge clk); #1;
            start_i = 1'b1; rank_i = 3'(rk);
            @(posedge clk); #1;
            start_i = 1'b0;
            rank_i  = (rk == 2) ? 3'd4 : 3'd2;   // R9: must not matter
            issued = 0; n = 0;
            while (issued < total) begin
                bit v;
                @(posedge clk); #1;
                case (CFG_CAD[c])
                    0: v = (n % 3) != 0;
                    1: v = 1'b1;
                    2: v = n[0];
                    default: v = lfsr[0];
                endcase
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                prod_vld_i = v;
                if (CFG_PAT[c] == 1)
                    prod_coef_i = (issued % 3 == 0) ? 12'd1 :
                                  (issued % 3 == 1) ? 12'd0 : 12'd3328;
                else
                    prod_coef_i = 12'((n * 1103 + c * 71 + 17) % Q);
                if (v) issued++;
                n++;
            end
            @(posedge clk); #1 prod_vld_i = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk);
            check(!busy_o, "R7 busy low after pass", int'(busy_o), 0);
            check(n_tdone == rk * rk, "R6 R9 term count", n_tdone, rk * rk);
            check(n_adone == 1, "R7 all-done pulses", n_adone, 1);
            mism = 0;
            for (int a = 0; a < rk * N; a++)
                if (int'(t_mem[a]) != exp_t[a]) mism++;
            check(mism == 0, "R8 R9 final result bank", mism, 0);
        end

        // R7: products after a pass are ignored
        prod_vld_i = 1'b1;
        @(negedge clk);
        check(!t_wr_en_o, "R7 product after pass ignored", int'(t_wr_en_o), 0);
        @(posedge clk); #1 prod_vld_i = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule